// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the wall-clock time and date as eight byte registers: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A prescaler divides a 32.768 kHz base tick, delivered as a one-cycle enable, down to one update per second. On each update the fields advance in the encoding selected by two control bits. The counts can be packed decimal or plain binary, and the hour can use a 24-hour count or a 12-hour count with a PM flag.

Two control registers manage the counter. Control register A holds a three-bit divider code that can run the prescaler, pause it, or hold it in reset. It also has a read-only update-in-progress flag, which warns software that the fields are about to change. Control register B has a freeze bit that stops the fields from advancing so that software can load a new time, plus the mode bits and an update-interrupt enable bit that it stores for the interrupt logic. A one-cycle strobe marks each completed update so that the alarm logic can compare times. Writes go through a byte write port. Reads come back one cycle later through a registered read port.

Top module: `tod_calendar`

## Requirements
- R1: After reset, the registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x00, century 0x20, control A 0x26 and control B 0x02. The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 control A, 9 control B. A read returns on `rd_data` one clock after `rd_addr` is presented.
- R2: While running, the time advances by one second every TICKS_PER_SEC base ticks. `upd_strobe` is high for exactly one cycle, in the same cycle that the new time values first appear.
- R3: When control B bit 2 is 0, fields are packed decimal (tens in bits 7:4, units in bits 3:0). In this mode, seconds and minutes wrap after 0x59, hours (24-hour) wrap after 0x23, day of week wraps 0x07 to 0x01, month wraps 0x12 to 0x01, and year and century wrap after 0x99. Each wrap carries into the next field, and year 99 carries into the century.
- R4: Day of month wraps to 1 after the month's last day: 30 for April, June, September and November; 28 for February, or 29 when the year is divisible by 4; 31 otherwise.
- R5: When control B bit 2 is 1, fields hold plain binary values with the same ranges and carries.
- R6: When control B bit 1 is 0 (12-hour mode), hours run 1 to 12 with bit 7 set for PM. 11 rolls to 12 and toggles bit 7. 12 rolls to 1 and keeps bit 7. Only the 11 PM to 12 AM step carries into the date.
- R7: While control B bit 7 (freeze) is 1, no update occurs and `upd_strobe` stays low. Host writes to time registers are stored as written. Clearing the bit resumes counting from the stored values.
- R8: A write to control B with bit 7 set stores bit 4 (update-interrupt enable) as 0. With bit 7 clear, bit 4 is stored as written.
- R9: Control A bit 7 reads 1 only while running, during the last UIP_TICKS base ticks before an update. It reads 0 when the counter is frozen or the divider is not running. Host writes to bit 7 are ignored.
- R10: When control A bits 6:5 are both 1, the divider is held in reset: no updates occur and bit 7 reads 0. After a write that releases it to a running code, the first update happens TICKS_PER_SEC/2 base ticks later.
- R11: With a divider code (control A bits 6:4) above 2 that is not a reset code, the prescaler pauses and no update occurs.
- R12: Addresses 10 to 15 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz base period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data, valid one cycle after rd_addr |
| upd_strobe | output | 1 | One-cycle pulse on each completed second update |

## Verification
The bound checker watches, on every cycle, the invariants that hold whatever the time is:
- the update strobe lasts a single cycle;
- the freeze bit suppresses updates;
- the seconds field never changes without a strobe or a host write to it;
- the update-in-progress flag is clear while the divider is in reset;
- the prescaler restarts at its half-second point when released from reset;
- a freezing write clears the interrupt enable.

The calendar arithmetic can only be shown by the directed scenarios, which preload edge dates in both encodings and both hour formats and read them back after one update. These cover year and century carries, month lengths, the leap-year rule and the 12-hour PM transitions. The scenarios also measure the update-in-progress window and the half-second delay after release.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam int NTIME  = 8;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  localparam logic [ADDR_W-1:0] AD_CTLA = 4'd8;
  localparam logic [ADDR_W-1:0] AD_CTLB = 4'd9;

  localparam int B_FREEZE = 7;
  localparam int B_UIE    = 4;
  localparam int B_BIN    = 2;
  localparam int B_H24    = 1;

  localparam logic [6:0] CTLA_RST = 7'h26;
  localparam logic [7:0] CTLB_RST = 8'h02;

  // encode a small integer in the selected number format
  function automatic logic [7:0] enc(input int n, input logic bin);
    if (bin) return 8'(n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  // increment in place in the selected format
  function automatic logic [7:0] step(input logic [7:0] v, input logic bin);
    if (bin) return v + 8'd1;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] y, input logic bin);
    if (bin) return (y[1:0] == 2'b00);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic int month_len(input logic [6:0] m, input logic leap);
    case (m)
      7'd2:                      return leap ? 29 : 28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 30;
      default:                   return 31;
    endcase
  endfunction
endpackage

// File: rtl/tod_divider.sv
`timescale 1ns/1ps
module tod_divider #(
  parameter int TICKS = 32768,
  parameter int UIP_N = 8,
  localparam int PW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [2:0]    div_code,
  input  logic          freeze,
  output logic          upd_go,
  output logic          uip,
  output logic          div_rst,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST      = PW'(TICKS - 1);
  localparam logic [PW-1:0] HALF      = PW'(TICKS / 2);
  localparam logic [PW-1:0] UIP_START = PW'(TICKS - UIP_N);

  logic div_run;
  logic wrap;

  assign div_rst = (div_code[2:1] == 2'b11);
  assign div_run = (div_code <= 3'd2);
  assign wrap    = tick_en && div_run && (phase == LAST);
  assign upd_go  = wrap && !freeze;
  assign uip     = div_run && !freeze && (phase >= UIP_START);

  always_ff @(posedge clk) begin
    if (rst)                      phase <= '0;
    else if (div_rst)             phase <= HALF;
    else if (tick_en && div_run)  phase <= wrap ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/tod_ctrl.sv
`timescale 1ns/1ps
module tod_ctrl
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wr_data,
  output logic [6:0] ctl_a,
  output logic [7:0] ctl_b
);
  logic [7:0] b_in;

  always_comb begin
    b_in = wr_data;
    if (wr_data[B_FREEZE]) b_in[B_UIE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a <= CTLA_RST;
      ctl_b <= CTLB_RST;
    end else begin
      if (wr_a) ctl_a <= wr_data[6:0];
      if (wr_b) ctl_b <= b_in;
    end
  end
endmodule

// File: rtl/tod_chain.sv
`timescale 1ns/1ps
module tod_chain
  import tod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd_go,
  input  logic                  bin,
  input  logic                  h24,
  input  logic                  wr_time,
  input  logic [2:0]            wr_sel,
  input  logic [7:0]            wr_data,
  output logic [NTIME-1:0][7:0] t_q,
  output logic                  upd_strobe
);
  logic [7:0] last_v [NTIME];
  logic [7:0] lo_v   [NTIME];
  logic [7:0] nx_v   [NTIME];
  logic [NTIME-1:0] at_last;
  logic [NTIME-1:0] adv;
  logic [7:0] hr_low, hr_step, e1, e12, hour_nx;
  logic       hour_wrap;
  logic       pm;

  // per-field limits
  always_comb begin
    last_v[F_SEC]  = enc(59, bin);  lo_v[F_SEC]  = enc(0, bin);
    last_v[F_MIN]  = enc(59, bin);  lo_v[F_MIN]  = enc(0, bin);
    last_v[F_HOUR] = enc(23, bin);  lo_v[F_HOUR] = enc(0, bin);
    last_v[F_DOW]  = enc(7, bin);   lo_v[F_DOW]  = enc(1, bin);
    last_v[F_DOM]  = enc(month_len(dec(t_q[F_MON], bin),
                                   is_leap(t_q[F_YEAR], bin)), bin);
    lo_v[F_DOM]    = enc(1, bin);
    last_v[F_MON]  = enc(12, bin);  lo_v[F_MON]  = enc(1, bin);
    last_v[F_YEAR] = enc(99, bin);  lo_v[F_YEAR] = enc(0, bin);
    last_v[F_CENT] = enc(99, bin);  lo_v[F_CENT] = enc(0, bin);
  end

  // hour handling for both formats
  always_comb begin
    pm      = t_q[F_HOUR][7];
    hr_low  = {1'b0, t_q[F_HOUR][6:0]};
    hr_step = step(hr_low, bin);
    e1      = enc(1, bin);
    e12     = enc(12, bin);
    if (h24) begin
      hour_wrap = (t_q[F_HOUR] == last_v[F_HOUR]);
      hour_nx   = hour_wrap ? lo_v[F_HOUR] : step(t_q[F_HOUR], bin);
    end else if (hr_low == e12) begin
      hour_wrap = 1'b0;
      hour_nx   = {pm, e1[6:0]};
    end else if (hr_low == enc(11, bin)) begin
      hour_wrap = pm;
      hour_nx   = {~pm, e12[6:0]};
    end else begin
      hour_wrap = 1'b0;
      hour_nx   = {pm, hr_step[6:0]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NTIME; g++) begin : g_field
      if (g == F_HOUR) begin : g_hr
        assign at_last[g] = hour_wrap;
        assign nx_v[g]    = hour_nx;
      end else begin : g_std
        assign at_last[g] = (t_q[g] == last_v[g]);
        assign nx_v[g]    = at_last[g] ? lo_v[g] : step(t_q[g], bin);
      end
    end
  endgenerate

  // carry chain
  always_comb begin
    adv[F_SEC]  = 1'b1;
    adv[F_MIN]  = at_last[F_SEC];
    adv[F_HOUR] = adv[F_MIN] & at_last[F_MIN];
    adv[F_DOW]  = adv[F_HOUR] & at_last[F_HOUR];
    adv[F_DOM]  = adv[F_HOUR] & at_last[F_HOUR];
    adv[F_MON]  = adv[F_DOM] & at_last[F_DOM];
    adv[F_YEAR] = adv[F_MON] & at_last[F_MON];
    adv[F_CENT] = adv[F_YEAR] & at_last[F_YEAR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q[F_SEC]  <= 8'h00;
      t_q[F_MIN]  <= 8'h00;
      t_q[F_HOUR] <= 8'h00;
      t_q[F_DOW]  <= 8'h01;
      t_q[F_DOM]  <= 8'h01;
      t_q[F_MON]  <= 8'h01;
      t_q[F_YEAR] <= 8'h00;
      t_q[F_CENT] <= 8'h20;
      upd_strobe  <= 1'b0;
    end else begin
      upd_strobe <= upd_go;
      for (int i = 0; i < NTIME; i++) begin
        if (wr_time && (wr_sel == 3'(i))) t_q[i] <= wr_data;
        else if (upd_go && adv[i])        t_q[i] <= nx_v[i];
      end
    end
  end
endmodule

// File: rtl/tod_calendar.sv
`timescale 1ns/1ps
module tod_calendar
  import tod_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  localparam int PW = $clog2(TICKS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              upd_strobe
);
  logic [6:0]            ctl_a;
  logic [7:0]            ctl_b;
  logic [NTIME-1:0][7:0] t_q;
  logic                  upd_go, uip, div_rst, freeze;
  logic [PW-1:0]         phase;
  logic                  wr_time;

  assign freeze  = ctl_b[B_FREEZE];
  assign wr_time = wr_en && (wr_addr < ADDR_W'(NTIME));

  tod_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .wr_a(wr_en && (wr_addr == AD_CTLA)),
    .wr_b(wr_en && (wr_addr == AD_CTLB)),
    .wr_data(wr_data), .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  tod_divider #(.TICKS(TICKS_PER_SEC), .UIP_N(UIP_TICKS)) u_div (
    .clk(clk), .rst(rst), .tick_en(tick_en), .div_code(ctl_a[6:4]),
    .freeze(freeze), .upd_go(upd_go), .uip(uip), .div_rst(div_rst),
    .phase(phase)
  );

  tod_chain u_chain (
    .clk(clk), .rst(rst), .upd_go(upd_go),
    .bin(ctl_b[B_BIN]), .h24(ctl_b[B_H24]),
    .wr_time(wr_time), .wr_sel(wr_addr[2:0]), .wr_data(wr_data),
    .t_q(t_q), .upd_strobe(upd_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else if (rd_addr < ADDR_W'(NTIME)) rd_data <= t_q[rd_addr[2:0]];
    else if (rd_addr == AD_CTLA)       rd_data <= {uip, ctl_a};
    else if (rd_addr == AD_CTLB)       rd_data <= ctl_b;
    else                               rd_data <= 8'h00;
  end
endmodule

// File: rtl/tod_calendar_chk.sv
`timescale 1ns/1ps
module tod_calendar_chk #(
  parameter int TICKS = 32768,
  localparam int PW = $clog2(TICKS)
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_strobe,
  input logic          freeze,
  input logic          div_rst,
  input logic          uip,
  input logic [PW-1:0] phase,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic [7:0]    ctl_b,
  input logic [7:0]    sec_q
);
  localparam logic [PW-1:0] HALF = PW'(TICKS / 2);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);

  p_sec_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 4'd0) |=> (upd_strobe || $stable(sec_q)));

  p_freeze_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    freeze |=> !upd_strobe);

  p_uie_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'd9 && wr_data[7]) |=> !ctl_b[4]);

  p_uip_low_in_reset_r10: assert property (@(posedge clk) disable iff (rst)
    div_rst |-> !uip);

  p_release_half_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(div_rst) |-> (phase == HALF));
endmodule

bind tod_calendar tod_calendar_chk #(.TICKS(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rst(rst), .upd_strobe(upd_strobe), .freeze(freeze),
  .div_rst(div_rst), .uip(uip), .phase(phase), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .ctl_b(ctl_b), .sec_q(t_q[0])
);

// File: tb/tod_calendar_test.sv
`timescale 1ns/1ps
module tod_calendar_test;
  localparam int TPS = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       upd_strobe;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tod_calendar #(.TICKS_PER_SEC(TPS), .UIP_TICKS(8)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .upd_strobe(upd_strobe)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, int'(v), int'(exp));
  endtask

  task automatic wait_upd(input string tag);
    int n = 0;
    while (!upd_strobe && n < 4 * TPS) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " update seen"}, int'(upd_strobe), 1);
  endtask

  task automatic count_upd(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (upd_strobe) cnt++;
    end
  endtask

  // preload all time fields under freeze, then release with mode byte
  task automatic load(input logic [7:0] mode, input logic [7:0] s, m, h,
                      dw, dm, mo, y, c);
    wr(4'd9, mode | 8'h80);
    wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, dw);
    wr(4'd4, dm); wr(4'd5, mo); wr(4'd6, y); wr(4'd7, c);
    wr(4'd9, mode);
  endtask

  task automatic t_reset();
    rchk("R1 sec", 4'd0, 8'h00); rchk("R1 min", 4'd1, 8'h00);
    rchk("R1 hour", 4'd2, 8'h00); rchk("R1 dow", 4'd3, 8'h01);
    rchk("R1 dom", 4'd4, 8'h01); rchk("R1 mon", 4'd5, 8'h01);
    rchk("R1 year", 4'd6, 8'h00); rchk("R1 cent", 4'd7, 8'h20);
    rchk("R1 ctla", 4'd8, 8'h26); rchk("R1 ctlb", 4'd9, 8'h02);
  endtask

  task automatic t_rate();
    int c;
    logic [7:0] s0;
    wait_upd("R2");
    rd(4'd0, s0);
    count_upd(2 * TPS - 2, c);
    chk("R2 strobes per two seconds", c, 2);
    rchk("R2 seconds advanced", 4'd0, s0 + 8'h02);
  endtask

  task automatic t_bcd_wrap();
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
    wait_upd("R3");
    rchk("R3 sec", 4'd0, 8'h00); rchk("R3 min", 4'd1, 8'h00);
    rchk("R3 hour", 4'd2, 8'h00); rchk("R3 dow", 4'd3, 8'h01);
    rchk("R3 dom", 4'd4, 8'h01); rchk("R3 mon", 4'd5, 8'h01);
    rchk("R3 year", 4'd6, 8'h00); rchk("R3 cent", 4'd7, 8'h21);
    load(8'h02, 8'h09, 8'h19, 8'h09, 8'h02, 8'h15, 8'h03, 8'h19, 8'h20);
    wait_upd("R3 digit");
    rchk("R3 units carry", 4'd0, 8'h10);
  endtask

  task automatic t_leap();
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24, 8'h20);
    wait_upd("R4 leap");
    rchk("R4 leap feb29 dom", 4'd4, 8'h29); rchk("R4 leap feb29 mon", 4'd5, 8'h02);
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24, 8'h20);
    wait_upd("R4 leap end");
    rchk("R4 leap mar1 dom", 4'd4, 8'h01); rchk("R4 leap mar1 mon", 4'd5, 8'h03);
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23, 8'h20);
    wait_upd("R4 common");
    rchk("R4 common dom", 4'd4, 8'h01); rchk("R4 common mon", 4'd5, 8'h03);
  endtask

  task automatic t_bin_12h();
    // binary, 12-hour: 11 PM, 59:59, April 30
    load(8'h04, 8'd59, 8'd59, 8'h8B, 8'd3, 8'd30, 8'd4, 8'd20, 8'd20);
    wait_upd("R6");
    rchk("R6 11pm to 12am", 4'd2, 8'h0C);
    rchk("R5 bin sec", 4'd0, 8'h00); rchk("R5 bin min", 4'd1, 8'h00);
    rchk("R4 april 30 dom", 4'd4, 8'h01); rchk("R5 bin mon", 4'd5, 8'h05);
    rchk("R5 bin dow", 4'd3, 8'h04);
    load(8'h04, 8'd59, 8'd59, 8'h0B, 8'd3, 8'd10, 8'd4, 8'd20, 8'd20);
    wait_upd("R6 noon");
    rchk("R6 11am to 12pm", 4'd2, 8'h8C); rchk("R6 no day carry", 4'd4, 8'd10);
    load(8'h04, 8'd59, 8'd59, 8'h8C, 8'd3, 8'd10, 8'd4, 8'd20, 8'd20);
    wait_upd("R6 one");
    rchk("R6 12pm to 1pm", 4'd2, 8'h81);
    load(8'h04, 8'd58, 8'd9, 8'd5, 8'd3, 8'd10, 8'd4, 8'd20, 8'd20);
    wait_upd("R5 step");
    rchk("R5 binary 58 to 59", 4'd0, 8'd59);
  endtask

  task automatic t_freeze();
    int c;
    wr(4'd9, 8'h82);
    wr(4'd0, 8'h10);
    count_upd(3 * TPS, c);
    chk("R7 no strobe while frozen", c, 0);
    rchk("R7 written value held", 4'd0, 8'h10);
    rchk("R9 uip low while frozen", 4'd8, 8'h26);
    wr(4'd9, 8'h02);
    wait_upd("R7 resume");
    rchk("R7 resumes from written", 4'd0, 8'h11);
  endtask

  task automatic t_uie();
    wr(4'd9, 8'h92);
    rchk("R8 freeze clears uie", 4'd9, 8'h82);
    wr(4'd9, 8'h12);
    rchk("R8 uie kept without freeze", 4'd9, 8'h12);
    wr(4'd9, 8'h02);
  endtask

  task automatic t_uip();
    wait_upd("R9");
    wr(4'd8, 8'hA6);
    rchk("R9 early in second, write of bit7 ignored", 4'd8, 8'h26);
    wait_upd("R9 window");
    repeat (TPS - 8) @(negedge clk);
    rchk("R9 uip set in final ticks", 4'd8, 8'hA6);
  endtask

  task automatic t_divreset();
    int c;
    logic [7:0] s0, s1;
    wr(4'd8, 8'h66);
    rd(4'd0, s0);
    count_upd(3 * TPS, c);
    chk("R10 no strobe in divider reset", c, 0);
    rd(4'd0, s1);
    chk("R10 seconds held in divider reset", int'(s1), int'(s0));
    rchk("R10 uip low in divider reset", 4'd8, 8'h66);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h26;
    @(negedge clk);
    wr_en = 1'b0;
    c = 0;
    for (int i = 0; i < TPS / 2 - 1; i++) begin
      @(negedge clk);
      if (upd_strobe) c++;
    end
    chk("R10 no update before half second", c, 0);
    @(negedge clk);
    chk("R10 first update at half second", int'(upd_strobe), 1);
  endtask

  task automatic t_paused();
    int c;
    wr(4'd8, 8'h46);
    count_upd(3 * TPS, c);
    chk("R11 paused code gives no update", c, 0);
    wr(4'd8, 8'h26);
  endtask

  task automatic t_unused();
    rchk("R12 unused reads zero", 4'd12, 8'h00);
    wr(4'd12, 8'h5A);
    rchk("R12 unused write ignored", 4'd12, 8'h00);
    wr(4'd15, 8'hFF);
    rchk("R12 unused write no side effect", 4'd9, 8'h02);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unused();
    t_rate();
    t_bcd_wrap();
    t_leap();
    t_bin_12h();
    t_freeze();
    t_uie();
    t_uip();
    t_divreset();
    t_paused();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule